// File: doc/BRIEF.md
# I2C Master Enable and Abort Controller

This block holds the three control bits of an I2C master: a master enable, a transfer-abort request and a command hold-off. It also sequences what happens when the master is switched on, switched off or told to abandon its transfer. Software writes and reads the control word through a plain register port. The block answers with flush requests to the transmit and receive FIFOs, a STOP request and a start permit to the serial bit engine, a not-acknowledge request for a receive that is being cut short, and a one-cycle abort interrupt pulse.

The bit engine reports back whether it is idle, when the current transfer completes, when a received byte ends and which direction it is moving data. The abort sequence waits for the running transfer to finish, then issues STOP, then flushes the transmit FIFO, then raises the interrupt, and only after that lets the abort bit drop. A disable lets a transmit finish before the transmit data is discarded. It ends a receive at the next byte boundary without acknowledging that byte. When asynchronous mode is selected, the enable level is carried into the I2C clock domain through a two-stage synchronizer.

Top module: `i2c_mst_enable_ctrl`

## Requirements
- R1: The control word has master enable at bit 0, abort at bit 1 and command hold-off at bit 2. Every other bit reads 0 and ignores writes, and every bit is 0 after reset.
- R2: A write with bit 1 set starts an abort only if the enable bit already read 1 before that write. Otherwise bit 1 stays 0.
- R3: Writing 0 to bit 1 does not clear a pending abort. Bit 1 reads 1 from the write that starts the abort until the abort sequence ends.
- R4: An abort waits until the engine reports transfer done or idle. It then drives `stop_req` for one cycle, then `txf_flush` for one cycle, then `abort_irq` for one cycle. Bit 1 reads 0 in the cycle after `abort_irq`.
- R5: While the enable bit is 0 and the block has settled after a disable, both `txf_flush` and `rxf_flush` stay high.
- R6: If the block is disabled while the engine is busy transmitting (`eng_rx`=0), no flush is requested until `xfer_done`. Both flushes then rise in the cycle after it.
- R7: If the block is disabled while the engine is busy receiving (`eng_rx`=1), `rx_nack` stays high until `byte_end`. Then `rx_nack` falls and both flushes rise.
- R8: `tx_start_ok` is high, one cycle after its inputs settle, only when the block is enabled and running, bit 2 is 0, `txf_empty` is 0 and no abort is in progress. With bit 2 at 1 it stays low even if the FIFO holds data.
- R9: `dis_active` rises with a disable write. It stays high through the drain and flush cycles and falls only once the engine reports idle.
- R10: In asynchronous mode `eng_en` takes the new enable level on the second rising edge of `ic_clk` after the write, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencing clock |
| rst | input | 1 | Synchronous active-high reset |
| ic_clk | input | 1 | I2C-domain clock for the enable synchronizer |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | REG_W | Control word write data |
| rd_data | output | REG_W | Current control word |
| eng_idle | input | 1 | Bit engine is idle |
| xfer_done | input | 1 | Pulse: current transfer has completed |
| byte_end | input | 1 | Pulse: a received byte has ended |
| eng_rx | input | 1 | Engine direction, 1 = receiving |
| txf_empty | input | 1 | Transmit FIFO is empty |
| txf_flush | output | 1 | Flush request to the transmit FIFO |
| rxf_flush | output | 1 | Flush request to the receive FIFO |
| stop_req | output | 1 | One-cycle STOP request to the engine |
| tx_start_ok | output | 1 | Engine may start a master command |
| rx_nack | output | 1 | Do not acknowledge the byte in progress |
| abort_irq | output | 1 | One-cycle abort-complete interrupt pulse |
| dis_active | output | 1 | Still active after a disable |
| eng_en | output | 1 | Enable level in the I2C clock domain |

## Verification
A stuck or skipped state in the abort sequencer shows up at the ports within one cycle. It appears as a STOP, flush or interrupt pulse out of order or missing, or as bit 1 dropping early or never dropping. A wrong drain state after disable shows as a premature flush in the transmit case, a missing or late `rx_nack` in the receive case, or `dis_active` falling while the engine is still busy. A fault in the hold-off or enable storage appears in `rd_data` in the cycle after the write and in `tx_start_ok` one cycle later. A wrong synchronizer depth moves the `eng_en` edge by one `ic_clk` period.

// File: rtl/i2c_en_pkg.sv
package i2c_en_pkg;
  localparam int BIT_EN  = 0;
  localparam int BIT_ABT = 1;
  localparam int BIT_BLK = 2;
  localparam int CTRL_W  = 3;

  typedef enum logic [2:0] {
    A_IDLE, A_WAIT, A_STOP, A_FLUSH, A_IRQ
  } abort_st_t;

  typedef enum logic [2:0] {
    D_OFF, D_RUN, D_TX, D_RX, D_FLUSH
  } dis_st_t;
endpackage

// File: rtl/i2c_en_regs.sv
module i2c_en_regs
  import i2c_en_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             abt_clr,
  output logic             en_q,
  output logic             abt_q,
  output logic             blk_q,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [REG_W-1:0] CTRL_MASK = REG_W'((1 << CTRL_W) - 1);
  localparam logic [REG_W-1:0] RSVD_MASK = ~CTRL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      abt_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      if (wr_en) begin
        en_q  <= wr_data[BIT_EN];
        blk_q <= wr_data[BIT_BLK];
      end
      if (abt_clr)
        abt_q <= 1'b0;
      else if (wr_en && wr_data[BIT_ABT] && en_q)
        abt_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_EN]  = en_q;
    rd_data[BIT_ABT] = abt_q;
    rd_data[BIT_BLK] = blk_q;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_data ^ $past(wr_data)) & RSVD_MASK) == ($past(wr_data) & RSVD_MASK));
  assert_abort_gate_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[BIT_ABT] && !en_q && !abt_q |=> !abt_q);
  assert_abort_hold_R3: assert property (@(posedge clk) disable iff (rst)
    abt_q && !abt_clr |=> abt_q);
endmodule

// File: rtl/i2c_abort_seq.sv
module i2c_abort_seq
  import i2c_en_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic abt_on,
  input  logic eng_idle,
  input  logic xfer_done,
  output logic stop_req,
  output logic tx_flush_p,
  output logic irq,
  output logic abt_clr,
  output logic seq_busy
);
  abort_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      A_IDLE:  if (abt_on) st_d = A_WAIT;
      A_WAIT:  if (eng_idle || xfer_done) st_d = A_STOP;
      A_STOP:  st_d = A_FLUSH;
      A_FLUSH: st_d = A_IRQ;
      A_IRQ:   st_d = A_IDLE;
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= A_IDLE;
    else     st_q <= st_d;
  end

  assign stop_req   = (st_q == A_STOP);
  assign tx_flush_p = (st_q == A_FLUSH);
  assign irq        = (st_q == A_IRQ);
  assign abt_clr    = (st_q == A_IRQ);
  assign seq_busy   = (st_q != A_IDLE);

  assert_stop_after_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_req) |-> $past(eng_idle || xfer_done));
  assert_stop_then_flush_R4: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> tx_flush_p && !stop_req);
  assert_flush_then_irq_R4: assert property (@(posedge clk) disable iff (rst)
    tx_flush_p |=> irq);
  assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq && !seq_busy);
endmodule

// File: rtl/i2c_dis_seq.sv
module i2c_dis_seq
  import i2c_en_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_on,
  input  logic eng_idle,
  input  logic eng_rx,
  input  logic xfer_done,
  input  logic byte_end,
  output logic flush_hold,
  output logic rx_nack,
  output logic dis_active,
  output logic run
);
  dis_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      D_OFF:   if (en_on) st_d = D_RUN;
      D_RUN:
        if (!en_on) begin
          if (eng_idle)    st_d = D_FLUSH;
          else if (eng_rx) st_d = D_RX;
          else             st_d = D_TX;
        end
      D_TX:    if (xfer_done || eng_idle) st_d = D_FLUSH;
      D_RX:    if (byte_end || eng_idle)  st_d = D_FLUSH;
      D_FLUSH: st_d = D_OFF;
      default: st_d = D_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= D_OFF;
    else     st_q <= st_d;
  end

  assign flush_hold = (st_q == D_OFF) || (st_q == D_FLUSH);
  assign rx_nack    = (st_q == D_RX);
  assign run        = (st_q == D_RUN) && en_on;
  assign dis_active = ((st_q == D_RUN) && !en_on) || (st_q == D_TX) ||
                      (st_q == D_RX) || (st_q == D_FLUSH) ||
                      ((st_q == D_OFF) && !eng_idle);

  assert_tx_drain_noflush_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == D_TX) && !xfer_done && !eng_idle |=> !flush_hold);
  assert_rx_nack_hold_R7: assert property (@(posedge clk) disable iff (rst)
    rx_nack && !byte_end && !eng_idle |=> rx_nack);
  assert_idle_before_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(dis_active) && !en_on |-> eng_idle);
endmodule

// File: rtl/i2c_en_sync.sv
module i2c_en_sync #(
  parameter bit ASYNC  = 1'b1,
  parameter int STAGES = 2
) (
  input  logic ic_clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (ASYNC) begin : g_sync
      logic [STAGES-1:0] sh;
      always_ff @(posedge ic_clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/i2c_mst_enable_ctrl.sv
module i2c_mst_enable_ctrl
  import i2c_en_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit ASYNC       = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ic_clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             eng_idle,
  input  logic             xfer_done,
  input  logic             byte_end,
  input  logic             eng_rx,
  input  logic             txf_empty,
  output logic             txf_flush,
  output logic             rxf_flush,
  output logic             stop_req,
  output logic             tx_start_ok,
  output logic             rx_nack,
  output logic             abort_irq,
  output logic             dis_active,
  output logic             eng_en
);
  logic en_q, abt_q, blk_q, abt_clr;
  logic a_flush, a_busy, d_flush, d_run;
  logic tx_ok_q;

  i2c_en_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .abt_clr(abt_clr), .en_q(en_q), .abt_q(abt_q), .blk_q(blk_q),
    .rd_data(rd_data)
  );

  i2c_abort_seq u_abort (
    .clk(clk), .rst(rst), .abt_on(abt_q), .eng_idle(eng_idle),
    .xfer_done(xfer_done), .stop_req(stop_req), .tx_flush_p(a_flush),
    .irq(abort_irq), .abt_clr(abt_clr), .seq_busy(a_busy)
  );

  i2c_dis_seq u_dis (
    .clk(clk), .rst(rst), .en_on(en_q), .eng_idle(eng_idle),
    .eng_rx(eng_rx), .xfer_done(xfer_done), .byte_end(byte_end),
    .flush_hold(d_flush), .rx_nack(rx_nack), .dis_active(dis_active),
    .run(d_run)
  );

  i2c_en_sync #(.ASYNC(ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .ic_clk(ic_clk), .rst(rst), .d(en_q), .q(eng_en)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_ok_q <= 1'b0;
    else     tx_ok_q <= d_run && !blk_q && !txf_empty && !a_busy;
  end

  assign tx_start_ok = tx_ok_q;
  assign txf_flush   = d_flush || a_flush;
  assign rxf_flush   = d_flush;

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    tx_start_ok |-> !$past(blk_q) && !$past(txf_empty));
  assert_off_flushed_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q && !dis_active |-> txf_flush && rxf_flush);
  assert_abort_blocks_start_R4: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> !tx_start_ok || !$past(a_busy));
endmodule

// File: tb/i2c_mst_enable_ctrl_tb_top.sv
module i2c_mst_enable_ctrl_tb_top;
  localparam int CLK_P  = 10;
  localparam int IC_P   = 16;
  localparam int REG_W  = 32;

  logic clk = 1'b0, ic_clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic eng_idle = 1'b1, xfer_done = 1'b0, byte_end = 1'b0, eng_rx = 1'b0, txf_empty = 1'b1;
  logic txf_flush, rxf_flush, stop_req, tx_start_ok, rx_nack, abort_irq, dis_active, eng_en;

  int vectors = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;
  always #(IC_P/2) ic_clk = ~ic_clk;

  i2c_mst_enable_ctrl #(.REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .ic_clk(ic_clk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .eng_idle(eng_idle), .xfer_done(xfer_done),
    .byte_end(byte_end), .eng_rx(eng_rx), .txf_empty(txf_empty),
    .txf_flush(txf_flush), .rxf_flush(rxf_flush), .stop_req(stop_req),
    .tx_start_ok(tx_start_ok), .rx_nack(rx_nack), .abort_irq(abort_irq),
    .dis_active(dis_active), .eng_en(eng_en)
  );

  task automatic chk(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic ic_write(input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {{(REG_W-1){1'b0}}, v};
    @(posedge clk);
    @(posedge ic_clk); #1;
    chk("R10 first ic edge", {31'b0, eng_en}, {31'b0, ~v});
    @(posedge ic_clk); #1;
    chk("R10 second ic edge", {31'b0, eng_en}, {31'b0, v});
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rd_data", rd_data, '0);
    chk("R5 reset flush", {30'b0, txf_flush, rxf_flush}, 32'h3);
    chk("R9 reset dis_active", {31'b0, dis_active}, '0);

    // R1 sweep: reserved bits ignored, ctrl bits stored (abort bit kept 0)
    for (int k = 0; k < 32; k++) begin
      logic [REG_W-1:0] d;
      d = ({8{k[3:0]}} ^ (32'h9E37_79B9 * k)) & ~32'h2;
      wr(d);
      chk("R1 sweep readback", rd_data, d & 32'h5);
    end
    wr(32'h0);
    repeat (3) @(negedge clk);

    // R2 abort write ignored while disabled
    wr(32'h2);
    chk("R2 abort alone disabled", rd_data, 32'h0);
    wr(32'h3);
    chk("R2 abort with enable in same write", rd_data, 32'h1);
    repeat (2) @(negedge clk);

    // R4 abort sequence with engine busy
    eng_idle = 1'b0;
    wr(32'h3);
    chk("R3 abort reads 1", rd_data, 32'h3);
    repeat (3) @(negedge clk);
    chk("R4 no stop before done", {31'b0, stop_req}, '0);
    wr(32'h1);
    chk("R3 sw clear ignored", rd_data, 32'h3);
    pulse_done();
    chk("R4 stop pulse", {30'b0, stop_req, txf_flush}, 32'h2);
    @(negedge clk);
    chk("R4 flush after stop", {30'b0, stop_req, txf_flush}, 32'h1);
    chk("R4 no irq yet", {31'b0, abort_irq}, '0);
    @(negedge clk);
    chk("R4 irq pulse", {31'b0, abort_irq}, 32'h1);
    chk("R3 abort still 1 at irq", rd_data, 32'h3);
    @(negedge clk);
    chk("R4 irq single", {31'b0, abort_irq}, '0);
    chk("R4 abort cleared", rd_data, 32'h1);

    // R8 hold-off sweep
    for (int b = 0; b < 2; b++) begin
      for (int e = 0; e < 2; e++) begin
        txf_empty = e[0];
        wr({29'b0, b[0], 2'b01});
        repeat (3) @(negedge clk);
        chk("R8 start permit", {31'b0, tx_start_ok}, {31'b0, (b == 0) && (e == 0)});
      end
    end
    txf_empty = 1'b1;
    wr(32'h1);

    // R6 disable while transmitting
    eng_idle = 1'b0; eng_rx = 1'b0;
    wr(32'h0);
    chk("R9 dis_active on disable", {31'b0, dis_active}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 no flush during tx drain", {30'b0, txf_flush, rxf_flush}, '0);
    chk("R7 no nack on tx", {31'b0, rx_nack}, '0);
    pulse_done();
    chk("R6 flush after done", {30'b0, txf_flush, rxf_flush}, 32'h3);
    @(negedge clk);
    chk("R9 busy while engine busy", {31'b0, dis_active}, 32'h1);
    eng_idle = 1'b1;
    #1;
    chk("R9 released on idle", {31'b0, dis_active}, '0);
    chk("R5 held flushed", {30'b0, txf_flush, rxf_flush}, 32'h3);

    // R7 disable while receiving
    wr(32'h1);
    repeat (2) @(negedge clk);
    eng_idle = 1'b0; eng_rx = 1'b1;
    wr(32'h0);
    repeat (2) @(negedge clk);
    chk("R7 nack during rx drain", {31'b0, rx_nack}, 32'h1);
    chk("R7 no rx flush yet", {31'b0, rxf_flush}, '0);
    @(negedge clk); byte_end = 1'b1;
    @(negedge clk); byte_end = 1'b0;
    chk("R7 nack released", {31'b0, rx_nack}, '0);
    chk("R7 flush after byte end", {30'b0, txf_flush, rxf_flush}, 32'h3);
    eng_idle = 1'b1; eng_rx = 1'b0;
    @(negedge clk);
    chk("R9 idle after rx", {31'b0, dis_active}, '0);

    // R10 enable crossing
    repeat (6) @(negedge clk);
    chk("R10 settled low", {31'b0, eng_en}, '0);
    ic_write(1'b1);
    repeat (4) @(negedge clk);
    ic_write(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule